// File: doc/BRIEF.md
# Switchable Encoding Selector with Per-Pair Trap Vectors

This machine-level control unit holds a writable vendor/architecture identifier pair. The active pair decides which of several instruction decoders is allowed to claim encodings. Every supported pair owns one decoder. The unit drives a one-hot enable vector, so exactly one decoder is live at any time.

Each supported pair also owns its own machine trap vector base and its own supervisor trap vector base. The unit presents the base that a trap would use: the entry of the active pair, for the privilege level that the trap targets.

Software changes the pair in two steps. It first stages a vendor value, then writes the architecture value. The combination is checked against the supported list, and an unsupported combination is dropped (WARL). A legal change does not happen at once. The unit raises a stall, waits until the pipeline reports that it has drained, and then moves the decoder enable and the vector set in the same clock edge. A trap that arrives before that edge is taken under the old pair, and the pending change is abandoned. Switching touches no extension state. Vector entries of inactive pairs keep their contents.

Top module: `enc_select_unit`

## Requirements
- R1: While `rst_n` is low, a clock edge returns the unit to pair 0. After such a reset, `dec_en` is 1 at bit 0 only, `stall_req` is low, and both vector entries of every pair read zero.
- R2: Supported pair i has the vendor ID `VENDOR_BASE + (i >> 1)` and the architecture ID `ARCH_BASE + i`. A write to CSR 0xF11 stages a vendor value. A write to CSR 0xF12 looks up the pair (staged vendor, written value). Reads of 0xF11 and 0xF12 return the IDs of the active pair, zero-extended.
- R3: An architecture write whose pair matches no supported entry leaves the active pair unchanged and does not raise `stall_req`.
- R4: `dec_en` always has exactly one bit set, and bit i is set when pair i is active.
- R5: A matching architecture write that names a pair other than the active one raises `stall_req` after the write edge. The old pair stays active while `drain_empty` is low. At the first edge that sees `drain_empty` high and `trap_req` low, the pair changes and `stall_req` drops together.
- R6: A `trap_req` while a switch is pending, or in the cycle of the architecture write itself, is served with the old pair's vector. The pending switch is discarded: `stall_req` is low afterwards and the pair does not change. If `trap_req` and `drain_empty` fall in the same cycle, the trap wins.
- R7: `trap_req` never changes the active pair or any vector entry.
- R8: CSR 0x305 (machine vector) and CSR 0x105 (supervisor vector) read and write only the entry of the active pair. Entries of other pairs keep their values across switches.
- R9: `trap_vec_base` is the active pair's machine entry when `trap_to_s` is 0, and its supervisor entry when `trap_to_s` is 1.
- R10: With `NUM_PAIRS` = 1, the identifier CSRs behave as read-only constants: writes never change their read value, never raise `stall_req` and never change `dec_en`.
- R11: An architecture write that matches the pair already active raises no stall and changes nothing.
- R12: While a switch is pending, writes to 0xF11 and 0xF12 are ignored. This holds for the staged vendor value as well, and the pending target is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| csr_we | input | 1 | CSR write strobe for `csr_addr` |
| csr_addr | input | 12 | CSR address for read and write |
| csr_wdata | input | XLEN | CSR write data |
| csr_rdata | output | XLEN | Combinational CSR read data for `csr_addr` |
| trap_req | input | 1 | A trap is being taken this cycle |
| trap_to_s | input | 1 | Trap target: 0 machine, 1 supervisor |
| drain_empty | input | 1 | Pipeline reports it is drained |
| dec_en | output | NUM_PAIRS | One-hot decoder enable |
| trap_vec_base | output | XLEN | Vector base for a trap at the selected level |
| stall_req | output | 1 | Switch pending; asks the pipeline to drain |

## Verification
The hazard case is a pending switch commit and a trap landing in the same cycle: `drain_empty` and `trap_req` are raised together while `stall_req` is high. A second form raises `trap_req` in the very cycle of the architecture write. The bench judges both by reading `trap_vec_base` before the edge, which must be the old pair's entry. After the edge it checks that `stall_req` is low and that `dec_en` still names the old pair. A further drain pulse must then cause no late switch.

// File: rtl/enc_sel_pkg.sv
`timescale 1ns/1ps
// Shared constants and helpers for the encoding selector.
// Assumes vendor identifiers are 32 bits wide and XLEN >= 32.
package enc_sel_pkg;
    localparam logic [11:0] CSR_ID_VENDOR = 12'hF11;
    localparam logic [11:0] CSR_ID_ARCH   = 12'hF12;
    localparam logic [11:0] CSR_VEC_M     = 12'h305;
    localparam logic [11:0] CSR_VEC_S     = 12'h105;

    // Vendor identity of supported pair idx: two pairs share each vendor value.
    function automatic logic [31:0] vendor_of(input logic [31:0] base, input int unsigned idx);
        return base + 32'(idx >> 1);
    endfunction
endpackage

// File: rtl/enc_pair_match.sv
`timescale 1ns/1ps
// Pair lookup: compares a candidate (vendor, arch) against every supported
// pair and returns hit/index. It also returns the IDs of the active index.
// Assumes the supported identities are unique, so at most one entry matches.
module enc_pair_match
    import enc_sel_pkg::*;
#(
    parameter int unsigned       NUM_PAIRS   = 4,
    parameter int unsigned       XLEN        = 32,
    parameter int unsigned       IDX_W       = 2,
    parameter logic [31:0]       VENDOR_BASE = 32'h0000_0A5C,
    parameter logic [XLEN-1:0]   ARCH_BASE   = XLEN'('hE100)
) (
    input  logic [31:0]      cand_vendor,
    input  logic [XLEN-1:0]  cand_arch,
    output logic             cand_hit,
    output logic [IDX_W-1:0] cand_idx,
    input  logic [IDX_W-1:0] act_idx,
    output logic [31:0]      act_vendor,
    output logic [XLEN-1:0]  act_arch
);
    // Architecture identity of supported pair i.
    function automatic logic [XLEN-1:0] arch_id(input int unsigned i);
        return ARCH_BASE + XLEN'(i);
    endfunction

    logic [NUM_PAIRS-1:0] hit_vec;

    // One comparator per supported pair.
    for (genvar g = 0; g < NUM_PAIRS; g++) begin : g_cmp
        assign hit_vec[g] = (cand_vendor == vendor_of(VENDOR_BASE, g))
                         && (cand_arch == arch_id(g));
    end

    // Encode the matching entry into an index.
    always_comb begin
        cand_hit = |hit_vec;
        cand_idx = '0;
        for (int unsigned i = 0; i < NUM_PAIRS; i++) begin
            if (hit_vec[i]) begin
                cand_idx = IDX_W'(i);
            end
        end
    end

    // Produce the identity of the active entry for CSR reads.
    always_comb begin
        act_vendor = vendor_of(VENDOR_BASE, 0);
        act_arch   = arch_id(0);
        for (int unsigned i = 0; i < NUM_PAIRS; i++) begin
            if (act_idx == IDX_W'(i)) begin
                act_vendor = vendor_of(VENDOR_BASE, i);
                act_arch   = arch_id(i);
            end
        end
    end
endmodule

// File: rtl/enc_switch_ctrl.sv
`timescale 1ns/1ps
// Switch controller: holds the staged vendor value, the active pair index and
// a pending switch. A switch waits for the pipeline to drain. A trap in the
// write cycle or while pending aborts it, so traps always see the old pair.
// Assumes match_hit/match_idx describe (staged_vendor, csr write data).
module enc_switch_ctrl #(
    parameter int unsigned NUM_PAIRS   = 4,
    parameter int unsigned IDX_W       = 2,
    parameter logic [31:0] VENDOR_BASE = 32'h0000_0A5C
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             vendor_we,
    input  logic [31:0]      vendor_wdata,
    input  logic             arch_we,
    input  logic             match_hit,
    input  logic [IDX_W-1:0] match_idx,
    input  logic             trap_req,
    input  logic             drain_empty,
    output logic [31:0]      staged_vendor,
    output logic [IDX_W-1:0] active_idx,
    output logic             pending
);
    logic [IDX_W-1:0] target_idx;
    logic             start_sw;
    logic             commit_sw;
    logic             abort_sw;

    // Decide this cycle's switch events.
    always_comb begin
        start_sw  = !pending && arch_we && match_hit
                 && (match_idx != active_idx) && !trap_req;
        abort_sw  = pending && trap_req;
        commit_sw = pending && !trap_req && drain_empty;
    end

    // Staged vendor value: only written while no switch is pending.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            staged_vendor <= VENDOR_BASE;
        end else if (vendor_we && !pending) begin
            staged_vendor <= vendor_wdata;
        end
    end

    // Pending flag and the target it carries.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending    <= 1'b0;
            target_idx <= '0;
        end else if (start_sw) begin
            pending    <= 1'b1;
            target_idx <= match_idx;
        end else if (abort_sw || commit_sw) begin
            pending    <= 1'b0;
        end
    end

    // Active pair: moves only on a commit edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_idx <= '0;
        end else if (commit_sw) begin
            active_idx <= target_idx;
        end
    end
endmodule

// File: rtl/enc_vec_table.sv
`timescale 1ns/1ps
// Per-pair trap vector storage: one machine and one supervisor base per pair.
// Only the entry at sel_idx is written or read. Assumes sel_idx < NUM_PAIRS.
module enc_vec_table #(
    parameter int unsigned NUM_PAIRS = 4,
    parameter int unsigned XLEN      = 32,
    parameter int unsigned IDX_W     = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] sel_idx,
    input  logic             m_we,
    input  logic             s_we,
    input  logic [XLEN-1:0]  wdata,
    output logic [XLEN-1:0]  m_rd,
    output logic [XLEN-1:0]  s_rd
);
    logic [XLEN-1:0] m_q [NUM_PAIRS];
    logic [XLEN-1:0] s_q [NUM_PAIRS];

    for (genvar g = 0; g < NUM_PAIRS; g++) begin : g_ent
        // Machine base of entry g.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                m_q[g] <= '0;
            end else if (m_we && (sel_idx == IDX_W'(g))) begin
                m_q[g] <= wdata;
            end
        end
        // Supervisor base of entry g.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                s_q[g] <= '0;
            end else if (s_we && (sel_idx == IDX_W'(g))) begin
                s_q[g] <= wdata;
            end
        end
    end

    // Read out the selected entry, guarded for non-power-of-two counts.
    always_comb begin
        m_rd = '0;
        s_rd = '0;
        for (int unsigned i = 0; i < NUM_PAIRS; i++) begin
            if (sel_idx == IDX_W'(i)) begin
                m_rd = m_q[i];
                s_rd = s_q[i];
            end
        end
    end
endmodule

// File: rtl/enc_select_unit.sv
`timescale 1ns/1ps
// Top: writable identifier pair selecting one decoder, with per-pair trap
// vector tables and a drained, atomic switch. Decoder enable and vector set
// derive from the same index register, so they change on one edge.
// Assumes a single CSR access per cycle and 32 <= XLEN <= 64.
module enc_select_unit
    import enc_sel_pkg::*;
#(
    parameter int unsigned     NUM_PAIRS   = 4,
    parameter int unsigned     XLEN        = 32,
    parameter logic [31:0]     VENDOR_BASE = 32'h0000_0A5C,
    parameter logic [XLEN-1:0] ARCH_BASE   = XLEN'('hE100)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 csr_we,
    input  logic [11:0]          csr_addr,
    input  logic [XLEN-1:0]      csr_wdata,
    output logic [XLEN-1:0]      csr_rdata,
    input  logic                 trap_req,
    input  logic                 trap_to_s,
    input  logic                 drain_empty,
    output logic [NUM_PAIRS-1:0] dec_en,
    output logic [XLEN-1:0]      trap_vec_base,
    output logic                 stall_req
);
    localparam int unsigned IDX_W = (NUM_PAIRS > 1) ? $clog2(NUM_PAIRS) : 1;

    logic             vendor_we, arch_we, vec_m_we, vec_s_we;
    logic [31:0]      staged_vendor, act_vendor;
    logic [XLEN-1:0]  act_arch, vec_m, vec_s;
    logic             match_hit, pending;
    logic [IDX_W-1:0] match_idx, active_idx;

    // Decode CSR write strobes.
    always_comb begin
        vendor_we = csr_we && (csr_addr == CSR_ID_VENDOR);
        arch_we   = csr_we && (csr_addr == CSR_ID_ARCH);
        vec_m_we  = csr_we && (csr_addr == CSR_VEC_M);
        vec_s_we  = csr_we && (csr_addr == CSR_VEC_S);
    end

    enc_pair_match #(
        .NUM_PAIRS(NUM_PAIRS), .XLEN(XLEN), .IDX_W(IDX_W),
        .VENDOR_BASE(VENDOR_BASE), .ARCH_BASE(ARCH_BASE)
    ) u_match (
        .cand_vendor(staged_vendor),
        .cand_arch  (csr_wdata),
        .cand_hit   (match_hit),
        .cand_idx   (match_idx),
        .act_idx    (active_idx),
        .act_vendor (act_vendor),
        .act_arch   (act_arch)
    );

    enc_switch_ctrl #(
        .NUM_PAIRS(NUM_PAIRS), .IDX_W(IDX_W), .VENDOR_BASE(VENDOR_BASE)
    ) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .vendor_we    (vendor_we),
        .vendor_wdata (csr_wdata[31:0]),
        .arch_we      (arch_we),
        .match_hit    (match_hit),
        .match_idx    (match_idx),
        .trap_req     (trap_req),
        .drain_empty  (drain_empty),
        .staged_vendor(staged_vendor),
        .active_idx   (active_idx),
        .pending      (pending)
    );

    enc_vec_table #(
        .NUM_PAIRS(NUM_PAIRS), .XLEN(XLEN), .IDX_W(IDX_W)
    ) u_vec (
        .clk    (clk),
        .rst_n  (rst_n),
        .sel_idx(active_idx),
        .m_we   (vec_m_we),
        .s_we   (vec_s_we),
        .wdata  (csr_wdata),
        .m_rd   (vec_m),
        .s_rd   (vec_s)
    );

    // One enable line per decoder engine.
    for (genvar g = 0; g < NUM_PAIRS; g++) begin : g_en
        assign dec_en[g] = (active_idx == IDX_W'(g));
    end

    // CSR read multiplexer.
    always_comb begin
        case (csr_addr)
            CSR_ID_VENDOR: csr_rdata = XLEN'(act_vendor);
            CSR_ID_ARCH:   csr_rdata = act_arch;
            CSR_VEC_M:     csr_rdata = vec_m;
            CSR_VEC_S:     csr_rdata = vec_s;
            default:       csr_rdata = '0;
        endcase
    end

    // Trap vector for the requested privilege level and the stall request.
    always_comb begin
        trap_vec_base = trap_to_s ? vec_s : vec_m;
        stall_req     = pending;
    end
endmodule

// File: rtl/enc_select_unit_chk.sv
`timescale 1ns/1ps
// Port-level checker for enc_select_unit, attached by bind below.
// Assumes synchronous active-low reset and one CSR access per cycle.
module enc_select_unit_chk
    import enc_sel_pkg::*;
#(
    parameter int unsigned NUM_PAIRS = 4,
    parameter int unsigned XLEN      = 32
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 csr_we,
    input logic [11:0]          csr_addr,
    input logic [XLEN-1:0]      csr_wdata,
    input logic [XLEN-1:0]      csr_rdata,
    input logic                 trap_req,
    input logic                 trap_to_s,
    input logic                 drain_empty,
    input logic [NUM_PAIRS-1:0] dec_en,
    input logic [XLEN-1:0]      trap_vec_base,
    input logic                 stall_req
);
    // R4
    dec_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(dec_en) == 1);

    // R5
    drain_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stall_req && !drain_empty && !trap_req) |=> (stall_req && $stable(dec_en)));

    // R5
    commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stall_req && drain_empty && !trap_req) |=> (!stall_req && !$stable(dec_en)));

    // R6
    trap_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stall_req && trap_req) |=> (!stall_req && $stable(dec_en)));

    // R7
    trap_keeps_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |=> $stable(dec_en));

    // R3
    idle_no_switch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !stall_req |=> $stable(dec_en));

    // R9
    vec_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_to_s == 1'b0 && csr_addr == CSR_VEC_M) |-> (trap_vec_base == csr_rdata));

    // R8
    vec_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_we && csr_addr == CSR_VEC_M && !stall_req)
        |=> (csr_addr != CSR_VEC_M || csr_rdata == $past(csr_wdata)));
endmodule

bind enc_select_unit enc_select_unit_chk #(
    .NUM_PAIRS(NUM_PAIRS), .XLEN(XLEN)
) u_chk (.*);

// File: tb/enc_select_unit_bench.sv
`timescale 1ns/1ps
// Directed bench: one task per scenario, each checking its own results.
module enc_select_unit_bench;
    localparam logic [11:0] A_VEN = 12'hF11, A_ARC = 12'hF12,
                            A_VM  = 12'h305, A_VS  = 12'h105;

    logic        clk = 1'b0, rst_n = 1'b0, csr_we = 1'b0;
    logic [11:0] csr_addr = '0;
    logic [31:0] csr_wdata = '0;
    logic        trap_req = 1'b0, trap_to_s = 1'b0, drain_empty = 1'b0;
    logic [31:0] csr_rdata, tvb, rdata1, tvb1;
    logic [3:0]  dec_en;
    logic [0:0]  dec1;
    logic        stall, stall1;
    int          total = 0, fails = 0;
    bit          done = 0;

    always #2 clk = ~clk;

    enc_select_unit u_enc_select_unit (
        .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_addr(csr_addr),
        .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .trap_req(trap_req),
        .trap_to_s(trap_to_s), .drain_empty(drain_empty), .dec_en(dec_en),
        .trap_vec_base(tvb), .stall_req(stall)
    );

    enc_select_unit #(.NUM_PAIRS(1)) u_enc_select_unit_one (
        .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_addr(csr_addr),
        .csr_wdata(csr_wdata), .csr_rdata(rdata1), .trap_req(trap_req),
        .trap_to_s(trap_to_s), .drain_empty(drain_empty), .dec_en(dec1),
        .trap_vec_base(tvb1), .stall_req(stall1)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        csr_we = 1'b1; csr_addr = a; csr_wdata = d;
        tick();
        csr_we = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        csr_addr = a; #0.5; d = csr_rdata;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        check("R1 dec_en", dec_en, 4'b0001);
        check("R1 stall", stall, 0);
        rd(A_VEN, v); check("R1 vendor", v, 32'hA5C);
        rd(A_ARC, v); check("R1 arch", v, 32'hE100);
        rd(A_VM, v);  check("R1 mvec", v, 0);
        rd(A_VS, v);  check("R1 svec", v, 0);
    endtask

    task automatic t_warl();
        logic [31:0] v;
        wr(A_ARC, 32'hE102);
        check("R3 stall", stall, 0);
        check("R3 dec_en", dec_en, 4'b0001);
        wr(A_ARC, 32'hDEAD);
        check("R3 stall2", stall, 0);
        rd(A_ARC, v); check("R3 arch", v, 32'hE100);
    endtask

    task automatic t_switch();
        logic [31:0] v;
        wr(A_ARC, 32'hE101);
        check("R5 stall up", stall, 1);
        check("R5 old dec", dec_en, 4'b0001);
        tick(); tick();
        check("R5 stall held", stall, 1);
        check("R5 old dec held", dec_en, 4'b0001);
        drain_empty = 1'b1; tick(); drain_empty = 1'b0;
        check("R5 new dec R4", dec_en, 4'b0010);
        check("R5 stall down", stall, 0);
        rd(A_ARC, v); check("R2 arch", v, 32'hE101);
    endtask

    task automatic t_same();
        wr(A_ARC, 32'hE101);
        check("R11 stall", stall, 0);
        check("R11 dec_en", dec_en, 4'b0010);
    endtask

    task automatic t_vec();
        logic [31:0] v;
        wr(A_VM, 32'h1000); wr(A_VS, 32'h2000);
        rd(A_VM, v); check("R8 mvec", v, 32'h1000);
        rd(A_VS, v); check("R8 svec", v, 32'h2000);
        trap_to_s = 1'b0; #0.5; check("R9 m level", tvb, 32'h1000);
        trap_to_s = 1'b1; #0.5; check("R9 s level", tvb, 32'h2000);
        trap_to_s = 1'b0;
        wr(A_VEN, 32'hA5D); drain_empty = 1'b1; wr(A_ARC, 32'hE102); tick();
        check("R2 dec pair2", dec_en, 4'b0100);
        rd(A_VEN, v); check("R2 vendor pair2", v, 32'hA5D);
        rd(A_VM, v);  check("R8 pair2 clear", v, 0);
        wr(A_VM, 32'h3000);
        wr(A_VEN, 32'hA5C); wr(A_ARC, 32'hE101); tick(); drain_empty = 1'b0;
        check("R8 back dec", dec_en, 4'b0010);
        rd(A_VM, v); check("R8 pair1 kept m", v, 32'h1000);
        rd(A_VS, v); check("R8 pair1 kept s", v, 32'h2000);
    endtask

    task automatic t_trap_abort();
        wr(A_VEN, 32'hA5D); wr(A_ARC, 32'hE103);
        check("R6 pending", stall, 1);
        trap_req = 1'b1; trap_to_s = 1'b0; #0.5;
        check("R6 old vector", tvb, 32'h1000);
        tick(); trap_req = 1'b0;
        check("R6 stall dropped", stall, 0);
        check("R6 pair kept", dec_en, 4'b0010);
        drain_empty = 1'b1; tick(); drain_empty = 1'b0;
        check("R6 no late switch", dec_en, 4'b0010);
    endtask

    task automatic t_trap_same_cycle();
        wr(A_ARC, 32'hE103);
        check("R6 pending2", stall, 1);
        drain_empty = 1'b1; trap_req = 1'b1;
        tick(); drain_empty = 1'b0; trap_req = 1'b0;
        check("R6 trap beats commit stall", stall, 0);
        check("R6 trap beats commit dec", dec_en, 4'b0010);
        trap_req = 1'b1; wr(A_ARC, 32'hE103); trap_req = 1'b0;
        check("R6 trap in write cycle", stall, 0);
    endtask

    task automatic t_trap_idle();
        logic [31:0] v;
        trap_req = 1'b1; tick(); tick(); trap_req = 1'b0;
        check("R7 dec kept", dec_en, 4'b0010);
        rd(A_VM, v); check("R7 vector kept", v, 32'h1000);
    endtask

    task automatic t_pending_ignored();
        logic [31:0] v;
        wr(A_ARC, 32'hE103);
        wr(A_VEN, 32'hA5C); wr(A_ARC, 32'hE100);
        check("R12 still pending", stall, 1);
        drain_empty = 1'b1; tick(); drain_empty = 1'b0;
        check("R12 target kept", dec_en, 4'b1000);
        rd(A_VEN, v); check("R2 vendor pair3", v, 32'hA5D);
        rd(A_ARC, v); check("R2 arch pair3", v, 32'hE103);
        wr(A_ARC, 32'hE102);
        check("R12 staged vendor kept", stall, 1);
        drain_empty = 1'b1; tick(); drain_empty = 1'b0;
        check("R12 pair2 again", dec_en, 4'b0100);
    endtask

    task automatic t_single();
        wr(A_VEN, 32'h1234); wr(A_ARC, 32'h99);
        wr(A_VEN, 32'hA5C);  wr(A_ARC, 32'hE100);
        csr_addr = A_VEN; #0.5; check("R10 vendor const", rdata1, 32'hA5C);
        csr_addr = A_ARC; #0.5; check("R10 arch const", rdata1, 32'hE100);
        check("R10 dec", dec1, 1'b1);
        check("R10 stall", stall1, 0);
    endtask

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        t_reset();
        t_warl();
        t_switch();
        t_same();
        t_vec();
        t_trap_abort();
        t_trap_same_cycle();
        t_trap_idle();
        t_pending_ignored();
        t_single();
        done = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            total++; fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end
endmodule